// File: doc/BRIEF.md
# Pad Configuration and Function-Select Register Bank

This block is the configuration store for one bank of 32 pads. Software writes it over a small 32-bit register port and the block drives the stored settings straight to the pad ring as parallel per-pin buses. Each pad gets a function-select value, where 0 means the pad belongs to the general-purpose I/O logic. Each pad also gets pull-up and pull-down enables, a slew control bit, an open-drain enable and a two-bit drive-strength code.

Not every pad position in a bank is bonded out. The parameter `AVAIL_MAP` marks the pads that exist, and software can read it back. The block masks every per-pin setting with this map, so an absent pad can never be given a configuration. Each bank decodes an 8-bit byte offset, which is a 0x100-byte window. Writes land on the clock edge at which `reg_wen` is high. Reads come back combinationally from the current offset.

Top module: `pad_cfg_bank`

## Requirements
- R1: The function select of pin n is at byte offset 4·n (n = 0..31). It stores `reg_wdata[FUNC_W-1:0]` and reads back zero-extended. It drives `pad_func[n*FUNC_W +: FUNC_W]`. Value 0 selects general-purpose I/O.
- R2: There is one bit per pin, with bit n = pin n. Pull-up enable is at 0x80, pull-down enable at 0x84, slew control at 0x88 and open-drain enable at 0x94. These drive `pad_pu`, `pad_pd`, `pad_slew` and `pad_od`.
- R3: Drive strength for pins 0..15 is at 0x8C and for pins 16..31 at 0x90. Pin k of each register sits at bits 2k+1:2k. Pin p drives `pad_drv[2p+1:2p]`. A write to one of the two registers leaves the other half unchanged.
- R4: Offset 0x98 reads `AVAIL_MAP`, where bit n = 1 means pin n exists. Writes to it change nothing.
- R5: A write to the function select of an unavailable pin is ignored, and that register reads 0.
- R6: In the registers of R2 and R3, bits of unavailable pins are forced to 0 on write, read as 0 and drive 0.
- R7: Offsets 0x9C..0xFC and any offset whose two low bits are not 00 are unmapped. Writes to them are ignored and they read 0.
- R8: After reset every function select is 0 and the pulls, slew and open-drain bits are 0. Drive strength is 2'b01 on available pins and 2'b00 on unavailable pins.
- R9: When pull-up and pull-down are both set for a pin, `pad_pd` for that pin is 0. The pull-down register still reads back the stored bit.
- R10: A write is visible on the pad outputs and in read data from the cycle after the edge at which `reg_wen` was sampled. Read data follows `reg_addr` without a clock.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| reg_wen | input | 1 | Write strobe, sampled on the rising edge |
| reg_addr | input | 8 | Byte offset within the bank window |
| reg_wdata | input | 32 | Write data |
| reg_rdata | output | 32 | Read data for `reg_addr`, combinational |
| pad_func | output | 32*FUNC_W | Per-pin function select |
| pad_pu | output | 32 | Per-pin pull-up enable |
| pad_pd | output | 32 | Per-pin pull-down enable, suppressed under pull-up |
| pad_slew | output | 32 | Per-pin slew control |
| pad_od | output | 32 | Per-pin open-drain enable |
| pad_drv | output | 64 | Per-pin drive strength, 2 bits per pin |

## Verification
The bench mixes random writes and reads over every offset, with biased choice of offset and full-range data. This shows whether each value lands in the right field of the right register and whether the availability mask is applied on every path. It also runs directed patterns:
- all-ones pulls on both registers, which separates the stored pull-down from the suppressed pad output;
- writes to the availability register, to unaligned offsets and to function selects of absent pins, each followed by a full readback;
- separate writes to the two drive registers, which expose any crossover between the halves.

// File: rtl/pad_cfg_bank.sv
module pad_cfg_bank #(
  parameter int          FUNC_W    = 4,
  parameter logic [31:0] AVAIL_MAP = 32'hF7FF_3FEF,
  parameter logic [1:0]  DRV_RESET = 2'b01
) (
  input  logic                  clk,
  input  logic                  rst_n,
  input  logic                  reg_wen,
  input  logic [7:0]            reg_addr,
  input  logic [31:0]           reg_wdata,
  output logic [31:0]           reg_rdata,
  output logic [32*FUNC_W-1:0]  pad_func,
  output logic [31:0]           pad_pu,
  output logic [31:0]           pad_pd,
  output logic [31:0]           pad_slew,
  output logic [31:0]           pad_od,
  output logic [63:0]           pad_drv
);

  function automatic logic [63:0] pair_fill(input logic [31:0] m, input logic [1:0] v);
    logic [63:0] r;
    r = '0;
    for (int i = 0; i < 32; i++) r[2*i +: 2] = m[i] ? v : 2'b00;
    return r;
  endfunction

  localparam int          NPIN     = 32;
  localparam logic [63:0] DRV_MASK = pair_fill(AVAIL_MAP, 2'b11);
  localparam logic [63:0] DRV_INIT = pair_fill(AVAIL_MAP, DRV_RESET);
  localparam logic [5:0]  IX_PU = 6'h20, IX_PD = 6'h21, IX_SL = 6'h22,
                          IX_DL = 6'h23, IX_DH = 6'h24, IX_OD = 6'h25, IX_AV = 6'h26;

  logic              aligned, wr;
  logic [5:0]        widx;
  logic [FUNC_W-1:0] func_q [NPIN];
  logic [31:0]       pu_q, pd_q, sl_q, od_q;
  logic [63:0]       drv_q;

  assign aligned = (reg_addr[1:0] == 2'b00);
  assign widx    = reg_addr[7:2];
  assign wr      = reg_wen && aligned;

  for (genvar p = 0; p < NPIN; p++) begin : g_pin
    if (AVAIL_MAP[p]) begin : g_live
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)                            func_q[p] <= '0;
        else if (wr && widx == 6'(p))          func_q[p] <= reg_wdata[FUNC_W-1:0];
      end
    end else begin : g_absent
      assign func_q[p] = '0;
    end
    assign pad_func[p*FUNC_W +: FUNC_W] = func_q[p];
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pu_q  <= '0;
      pd_q  <= '0;
      sl_q  <= '0;
      od_q  <= '0;
      drv_q <= DRV_INIT;
    end else if (wr) begin
      case (widx)
        IX_PU: pu_q <= reg_wdata & AVAIL_MAP;
        IX_PD: pd_q <= reg_wdata & AVAIL_MAP;
        IX_SL: sl_q <= reg_wdata & AVAIL_MAP;
        IX_OD: od_q <= reg_wdata & AVAIL_MAP;
        IX_DL: drv_q[31:0]  <= reg_wdata & DRV_MASK[31:0];
        IX_DH: drv_q[63:32] <= reg_wdata & DRV_MASK[63:32];
        default: ;
      endcase
    end
  end

  assign pad_pu   = pu_q;
  assign pad_pd   = pd_q & ~pu_q;
  assign pad_slew = sl_q;
  assign pad_od   = od_q;
  assign pad_drv  = drv_q;

  always_comb begin
    reg_rdata = '0;
    if (aligned) begin
      if (!widx[5]) reg_rdata[FUNC_W-1:0] = func_q[widx[4:0]];
      else begin
        case (widx)
          IX_PU: reg_rdata = pu_q;
          IX_PD: reg_rdata = pd_q;
          IX_SL: reg_rdata = sl_q;
          IX_OD: reg_rdata = od_q;
          IX_DL: reg_rdata = drv_q[31:0];
          IX_DH: reg_rdata = drv_q[63:32];
          IX_AV: reg_rdata = AVAIL_MAP;
          default: reg_rdata = '0;
        endcase
      end
    end
  end

  AST_ABSENT_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
    (((pad_pu | pad_pd | pad_slew | pad_od) & ~AVAIL_MAP) == 32'h0) && ((pad_drv & ~DRV_MASK) == 64'h0)); // R6
  AST_PU_WRITE: assert property (@(posedge clk) disable iff (!rst_n)
    (reg_wen && reg_addr == 8'h80) |=> (pad_pu == ($past(reg_wdata) & AVAIL_MAP))); // R2
  AST_AVAIL_RO: assert property (@(posedge clk) disable iff (!rst_n)
    (reg_wen && reg_addr == 8'h98) |=> ($stable(pad_pu) && $stable(pad_pd) && $stable(pad_slew)
                                        && $stable(pad_od) && $stable(pad_drv) && $stable(pad_func))); // R4
  AST_UNALIGNED_IGNORED: assert property (@(posedge clk) disable iff (!rst_n)
    (reg_wen && reg_addr[1:0] != 2'b00) |=> ($stable(pad_pu) && $stable(pad_drv) && $stable(pad_func))); // R7
  AST_DRV_HALVES: assert property (@(posedge clk) disable iff (!rst_n)
    (reg_wen && reg_addr == 8'h90) |=> $stable(pad_drv[31:0])); // R3

endmodule

// File: tb/sim_pad_cfg_bank.sv
`timescale 1ns/1ps
module sim_pad_cfg_bank;
  localparam int          FW = 4;
  localparam logic [31:0] AV = 32'hF7FF_3FEF;

  logic clk = 0, rst_n = 0, reg_wen = 0;
  logic [7:0] reg_addr = 0;
  logic [31:0] reg_wdata = 0, reg_rdata;
  logic [32*FW-1:0] pad_func;
  logic [31:0] pad_pu, pad_pd, pad_slew, pad_od;
  logic [63:0] pad_drv;

  int n_run = 0, n_fail = 0;

  always #2.5 clk = ~clk;

  pad_cfg_bank #(.FUNC_W(FW), .AVAIL_MAP(AV), .DRV_RESET(2'b01)) u0 (
    .clk(clk), .rst_n(rst_n), .reg_wen(reg_wen), .reg_addr(reg_addr),
    .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .pad_func(pad_func),
    .pad_pu(pad_pu), .pad_pd(pad_pd), .pad_slew(pad_slew), .pad_od(pad_od),
    .pad_drv(pad_drv));

  logic [FW-1:0] m_func [32];
  logic [31:0]   m_pu, m_pd, m_sl, m_od;
  logic [63:0]   m_drv, dmask;

  task automatic chk(input string req, input logic [127:0] got, input logic [127:0] exp);
    n_run++;
    if (got !== exp) begin
      n_fail++;
      $display("FAIL %s: got %h expected %h", req, got, exp);
    end
  endtask

  task automatic model_reset();
    dmask = '0;
    m_drv = '0;
    for (int i = 0; i < 32; i++) begin
      m_func[i] = '0;
      if (AV[i]) begin
        dmask[2*i +: 2] = 2'b11;
        m_drv[2*i +: 2] = 2'b01;
      end
    end
    m_pu = 0; m_pd = 0; m_sl = 0; m_od = 0;
  endtask

  task automatic model_write(input logic [7:0] a, input logic [31:0] d);
    int ix;
    if (a[1:0] != 2'b00) return;
    ix = int'(a[7:2]);
    if (ix < 32) begin
      if (AV[ix]) m_func[ix] = d[FW-1:0];
    end else begin
      case (ix)
        32: m_pu = d & AV;
        33: m_pd = d & AV;
        34: m_sl = d & AV;
        35: m_drv[31:0]  = d & dmask[31:0];
        36: m_drv[63:32] = d & dmask[63:32];
        37: m_od = d & AV;
        default: ;
      endcase
    end
  endtask

  function automatic logic [31:0] model_read(input logic [7:0] a);
    int ix;
    if (a[1:0] != 2'b00) return 32'h0;
    ix = int'(a[7:2]);
    if (ix < 32) return 32'(m_func[ix]);
    case (ix)
      32: return m_pu;
      33: return m_pd;
      34: return m_sl;
      35: return m_drv[31:0];
      36: return m_drv[63:32];
      37: return m_od;
      38: return AV;
      default: return 32'h0;
    endcase
  endfunction

  task automatic wr(input logic [7:0] a, input logic [31:0] d);
    @(negedge clk);
    reg_wen = 1; reg_addr = a; reg_wdata = d;
    @(negedge clk);
    reg_wen = 0;
    model_write(a, d);
  endtask

  task automatic rd_chk(input string req, input logic [7:0] a);
    @(negedge clk);
    reg_addr = a;
    #1;
    chk(req, 128'(reg_rdata), 128'(model_read(a)));
  endtask

  task automatic out_chk();
    logic [32*FW-1:0] ef;
    for (int i = 0; i < 32; i++) ef[i*FW +: FW] = m_func[i];
    #1;
    chk("R1 pad_func", 128'(pad_func), 128'(ef));
    chk("R2 pad_pu", 128'(pad_pu), 128'(m_pu));
    chk("R9 pad_pd", 128'(pad_pd), 128'(m_pd & ~m_pu));
    chk("R2 pad_slew", 128'(pad_slew), 128'(m_sl));
    chk("R2 pad_od", 128'(pad_od), 128'(m_od));
    chk("R3 pad_drv", 128'(pad_drv), 128'(m_drv));
  endtask

  task automatic full_readback(input string req);
    for (int i = 0; i < 64; i++) rd_chk(req, 8'(i * 4));
  endtask

  initial begin
    #(5.0 * 150000);
    n_fail++;
    $display("FAIL watchdog: got timeout expected completion");
    $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end

  initial begin
    void'($urandom(32'd1234));
    model_reset();
    repeat (3) @(negedge clk);
    rst_n = 1;
    @(negedge clk);
    out_chk();
    full_readback("R8 reset readback");

    wr(8'h80, 32'hFFFF_FFFF);
    wr(8'h84, 32'hFFFF_FFFF);
    out_chk();
    chk("R9 pad_pd suppressed", 128'(pad_pd), 128'h0);
    rd_chk("R9 stored pull-down", 8'h84);
    chk("R6 pull-up masked", 128'(pad_pu), 128'(AV));

    wr(8'h98, 32'h0);
    rd_chk("R4 avail read-only", 8'h98);
    chk("R4 avail value", 128'(reg_rdata), 128'(AV));
    out_chk();

    wr(8'h81, 32'h0);
    wr(8'h12, 32'hF);
    wr(8'hA0, 32'hFFFF_FFFF);
    out_chk();
    rd_chk("R7 unaligned reads 0", 8'h85);
    rd_chk("R7 unmapped reads 0", 8'hFC);
    chk("R7 unmapped value", 128'(reg_rdata), 128'h0);

    wr(8'h10, 32'hF);
    rd_chk("R5 absent pin func", 8'h10);
    chk("R5 absent pin value", 128'(reg_rdata), 128'h0);
    wr(8'h0C, 32'h0000_0007);
    rd_chk("R1 func pin3", 8'h0C);
    chk("R1 func pin3 value", 128'(reg_rdata), 128'h7);
    chk("R10 pin3 on pad", 128'(pad_func[3*FW +: FW]), 128'h7);

    wr(8'h8C, 32'hFFFF_FFFF);
    wr(8'h90, 32'h0);
    out_chk();
    rd_chk("R3 drive low half", 8'h8C);
    rd_chk("R6 drive masked", 8'h90);

    for (int it = 0; it < 600; it++) begin
      logic [7:0] a;
      int pick;
      pick = int'($urandom_range(0, 45));
      if (pick < 32)      a = 8'(pick * 4);
      else if (pick < 39) a = 8'(8'h80 + (pick - 32) * 4);
      else                a = 8'($urandom_range(0, 255));
      if ($urandom_range(0, 2) != 0) begin
        wr(a, $urandom());
        out_chk();
      end else begin
        rd_chk("R10 random read", a);
      end
    end
    full_readback("R6 final readback");
    out_chk();

    $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end
endmodule